// File: doc/BRIEF.md
# Checksummed Register-Access I2C Target Transaction Layer

This block is the transaction layer of an I2C target that holds a 48-byte register file. A byte-level front end handles SCL/SDA, filtering and clock stretching. It delivers bus events to this block: start or repeated start, stop, the matched target-address byte with its direction bit, and each received data byte. It also delivers a request each time it needs the next byte to send. The block answers each received byte with ACK or NAK and keeps the next transmit byte ready on its output.

Two access styles are supported. In a plain access, the first byte of a write phase selects a register pointer. Later written bytes land at consecutive locations. A read phase returns bytes from the pointer onward. A checked access replaces the pointer byte with the command code 0x80, followed by a byte count (1 to 16) and a base address. A checked write takes that many data bytes into a staging buffer, then one checksum byte. The checksum is the modulo-256 sum of count, base and data. The staged bytes are copied into the register file in a single cycle, and only when the checksum matches. A checked read uses a write phase that carries only command, count and base. The following read phase returns count bytes and then the checksum over count, base and those bytes.

Top module: `ckreg_i2c_target`

## Requirements
- R1: After reset every register reads 0x00 and the plain pointer is 0.
- R2: In a plain write, the first byte after the address sets the pointer and is ACKed. Each further byte is written at the pointer, ACKed, and the pointer then increments.
- R3: In a plain read phase, tx_data_o shows the register at the pointer, and each tx_req_i advances the pointer. The pointer survives stop and repeated start.
- R4: A plain write byte aimed at a location of 48 or above is NAKed and changes nothing. A plain read there returns 0xFF.
- R5: A first byte of 0x80 starts a checked access and is ACKed. A count byte of 0 or above 16 is NAKed, and all later bytes are NAKed until the next start or stop.
- R6: A checked write whose checksum byte equals (count + base + data) mod 256 ACKs that byte and updates all count registers in the same cycle.
- R7: A checked write with a wrong checksum NAKs the checksum byte and leaves every register unchanged.
- R8: A stop or start that arrives after at least one checked data byte but before the checksum byte discards the staged bytes without writing any register.
- R9: A checked read returns count bytes from base upward, then the checksum over count, base and those bytes. No register is read for the checksum slot.
- R10: A checked base byte for which base + count exceeds 48 is NAKed and aborts the access.
- R11: Bytes received after a checked-write checksum byte are NAKed, and read requests after a checked-read checksum return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start or repeated start seen, one-cycle pulse |
| stop_i | input | 1 | Stop seen, one-cycle pulse |
| addr_i | input | 1 | Own target address received, one-cycle pulse |
| rw_i | input | 1 | Direction bit with addr_i, 1 = read |
| rx_valid_i | input | 1 | Received data byte valid, one-cycle pulse |
| rx_data_i | input | 8 | Received data byte |
| ack_o | output | 1 | ACK (1) or NAK (0) for the byte on rx_data_i, valid while rx_valid_i is high |
| tx_req_i | input | 1 | Front end takes tx_data_o, one-cycle pulse |
| tx_data_o | output | 8 | Byte to transmit on the next request |

## Verification
In a checked read, the request that takes the last data byte does two things in the same cycle: it folds that byte into the running sum and it switches the output from register data to the checksum. The checksum shown next must therefore already include the byte that has just left. The bench provokes this with directed counts of 1 and 16 and with random counts. It compares every returned byte and the trailing checksum against sums it computes from its own register model. On the write side, the checksum compare and the multi-register commit fall in the cycle of the checksum byte. Readback after matched and corrupted checksums shows whether all the staged bytes moved together or none did.

// File: rtl/ckreg_pkg.sv
package ckreg_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_CMD, ST_PWR, ST_CNT, ST_CADR, ST_CDAT,
    ST_CSUM, ST_ARM, ST_PRD, ST_CRD, ST_DROP
  } ck_state_e;
endpackage

// File: rtl/ckreg_regfile.sv
module ckreg_regfile #(
  parameter int unsigned NREG = 48,
  parameter int unsigned NSTG = 16,
  localparam int unsigned AW = $clog2(NREG),
  localparam int unsigned SW = $clog2(NSTG),
  localparam int unsigned CW = $clog2(NSTG + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [7:0]                 waddr_i,
  input  logic [7:0]                 wdata_i,
  input  logic                       commit_i,
  input  logic [7:0]                 cbase_i,
  input  logic [CW-1:0]              ccnt_i,
  input  logic [NSTG-1:0][7:0]       stage_i,
  input  logic [7:0]                 raddr_i,
  output logic [7:0]                 rdata_o,
  output logic [NREG-1:0][7:0]       regs_o
);
  logic [8:0] win_end;
  assign win_end = {1'b0, cbase_i} + 9'(ccnt_i);

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [7:0] off;
    logic       in_win;
    assign off    = 8'(i) - cbase_i;
    assign in_win = (9'(i) >= {1'b0, cbase_i}) && (9'(i) < win_end);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                regs_o[i] <= '0;
      else if (commit_i && in_win)                regs_o[i] <= stage_i[off[SW-1:0]];
      else if (we_i && waddr_i == 8'(i))          regs_o[i] <= wdata_i;
    end
  end

  assign rdata_o = (raddr_i < 8'(NREG)) ? regs_o[raddr_i[AW-1:0]] : 8'hFF;
endmodule

// File: rtl/ckreg_stage.sv
module ckreg_stage #(
  parameter int unsigned NSTG = 16,
  localparam int unsigned SW = $clog2(NSTG)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [SW-1:0]        widx_i,
  input  logic [7:0]           wdata_i,
  output logic [NSTG-1:0][7:0] buf_o
);
  for (genvar i = 0; i < NSTG; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              buf_o[i] <= '0;
      else if (wr_i && widx_i == SW'(i))        buf_o[i] <= wdata_i;
    end
  end
endmodule

// File: rtl/ckreg_ctrl.sv
module ckreg_ctrl
  import ckreg_pkg::*;
#(
  parameter int unsigned NREG = 48,
  parameter int unsigned NSTG = 16,
  parameter logic [7:0]  CMD_CHK = 8'h80,
  localparam int unsigned SW = $clog2(NSTG),
  localparam int unsigned CW = $clog2(NSTG + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          addr_i,
  input  logic          rw_i,
  input  logic          rx_valid_i,
  input  logic [7:0]    rx_data_i,
  input  logic          tx_req_i,
  input  logic [7:0]    rdata_i,
  output logic          ack_o,
  output logic [7:0]    tx_data_o,
  output logic          we_o,
  output logic [7:0]    waddr_o,
  output logic          commit_o,
  output logic [7:0]    base_o,
  output logic [CW-1:0] cnt_o,
  output logic          stg_wr_o,
  output logic [SW-1:0] stg_idx_o,
  output logic [7:0]    raddr_o,
  output logic          rd_en_o,
  output ck_state_e     st_o,
  output logic [CW-1:0] idx_o
);
  ck_state_e     st_q;
  logic [7:0]    ptr_q, sum_q;
  logic [CW-1:0] cnt_q, idx_q;
  logic          ptr_ok, cnt_ok, win_ok, sum_ok, last_dat, keep_arm;

  assign ptr_ok   = ptr_q < 8'(NREG);
  assign cnt_ok   = (rx_data_i != 8'd0) && (rx_data_i <= 8'(NSTG));
  assign win_ok   = ({1'b0, rx_data_i} + 9'(cnt_q)) <= 9'(NREG);
  assign sum_ok   = rx_data_i == sum_q;
  assign last_dat = idx_q == cnt_q - CW'(1);
  assign keep_arm = (st_q == ST_CDAT && idx_q == '0) || st_q == ST_ARM;

  always_comb begin
    ack_o = 1'b0;
    if (rx_valid_i) begin
      unique case (st_q)
        ST_CMD:  ack_o = 1'b1;
        ST_PWR:  ack_o = ptr_ok;
        ST_CNT:  ack_o = cnt_ok;
        ST_CADR: ack_o = win_ok;
        ST_CDAT: ack_o = 1'b1;
        ST_CSUM: ack_o = sum_ok;
        default: ack_o = 1'b0;
      endcase
    end
  end

  assign we_o      = rx_valid_i && st_q == ST_PWR && ptr_ok;
  assign waddr_o   = ptr_q;
  assign commit_o  = rx_valid_i && st_q == ST_CSUM && sum_ok;
  assign base_o    = ptr_q;
  assign cnt_o     = cnt_q;
  assign stg_wr_o  = rx_valid_i && st_q == ST_CDAT;
  assign stg_idx_o = idx_q[SW-1:0];
  assign rd_en_o   = (st_q == ST_PRD && ptr_ok) || (st_q == ST_CRD && idx_q < cnt_q);
  assign raddr_o   = (st_q == ST_CRD) ? ptr_q + 8'(idx_q) : ptr_q;
  assign tx_data_o = rd_en_o ? rdata_i :
                     (st_q == ST_CRD && idx_q == cnt_q) ? sum_q : 8'hFF;
  assign st_o      = st_q;
  assign idx_o     = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      ptr_q <= '0;
      sum_q <= '0;
      cnt_q <= '0;
      idx_q <= '0;
    end else if (start_i || stop_i) begin
      st_q <= keep_arm ? ST_ARM : ST_IDLE;
    end else if (addr_i) begin
      if (!rw_i) st_q <= ST_CMD;
      else if (st_q == ST_ARM) begin
        st_q  <= ST_CRD;
        idx_q <= '0;
      end else st_q <= ST_PRD;
    end else if (rx_valid_i) begin
      unique case (st_q)
        ST_CMD: begin
          if (rx_data_i == CMD_CHK) st_q <= ST_CNT;
          else begin
            ptr_q <= rx_data_i;
            st_q  <= ST_PWR;
          end
        end
        ST_PWR: if (ptr_ok) ptr_q <= ptr_q + 8'd1;
        ST_CNT: begin
          if (cnt_ok) begin
            cnt_q <= CW'(rx_data_i);
            sum_q <= rx_data_i;
            st_q  <= ST_CADR;
          end else st_q <= ST_DROP;
        end
        ST_CADR: begin
          if (win_ok) begin
            ptr_q <= rx_data_i;
            sum_q <= sum_q + rx_data_i;
            idx_q <= '0;
            st_q  <= ST_CDAT;
          end else st_q <= ST_DROP;
        end
        ST_CDAT: begin
          sum_q <= sum_q + rx_data_i;
          idx_q <= idx_q + CW'(1);
          if (last_dat) st_q <= ST_CSUM;
        end
        ST_CSUM: st_q <= ST_DROP;
        default: ;
      endcase
    end else if (tx_req_i) begin
      if (st_q == ST_PRD && ptr_ok) ptr_q <= ptr_q + 8'd1;
      else if (st_q == ST_CRD) begin
        if (idx_q < cnt_q) begin
          sum_q <= sum_q + rdata_i;
          idx_q <= idx_q + CW'(1);
        end else st_q <= ST_DROP;
      end
    end
  end
endmodule

// File: rtl/ckreg_i2c_target.sv
module ckreg_i2c_target
  import ckreg_pkg::*;
#(
  parameter int unsigned NREG = 48,
  parameter int unsigned NSTG = 16,
  parameter logic [7:0]  CMD_CHK = 8'h80
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic       addr_i,
  input  logic       rw_i,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_data_i,
  output logic       ack_o,
  input  logic       tx_req_i,
  output logic [7:0] tx_data_o
);
  localparam int unsigned SW = $clog2(NSTG);
  localparam int unsigned CW = $clog2(NSTG + 1);

  logic                 we, commit, stg_wr, rd_en;
  logic [7:0]           waddr, base, raddr, rdata;
  logic [CW-1:0]        cnt, idx;
  logic [SW-1:0]        stg_idx;
  logic [NSTG-1:0][7:0] stage;
  logic [NREG-1:0][7:0] regs;
  ck_state_e            st;

  ckreg_ctrl #(.NREG(NREG), .NSTG(NSTG), .CMD_CHK(CMD_CHK)) i_ctrl (
    .clk_i, .rst_ni, .start_i, .stop_i, .addr_i, .rw_i, .rx_valid_i, .rx_data_i,
    .tx_req_i, .rdata_i(rdata), .ack_o, .tx_data_o, .we_o(we), .waddr_o(waddr),
    .commit_o(commit), .base_o(base), .cnt_o(cnt), .stg_wr_o(stg_wr),
    .stg_idx_o(stg_idx), .raddr_o(raddr), .rd_en_o(rd_en), .st_o(st), .idx_o(idx)
  );

  ckreg_stage #(.NSTG(NSTG)) i_stage (
    .clk_i, .rst_ni, .wr_i(stg_wr), .widx_i(stg_idx), .wdata_i(rx_data_i), .buf_o(stage)
  );

  ckreg_regfile #(.NREG(NREG), .NSTG(NSTG)) i_regfile (
    .clk_i, .rst_ni, .we_i(we), .waddr_i(waddr), .wdata_i(rx_data_i),
    .commit_i(commit), .cbase_i(base), .ccnt_i(cnt), .stage_i(stage),
    .raddr_i(raddr), .rdata_o(rdata), .regs_o(regs)
  );
endmodule

// File: rtl/ckreg_chk.sv
module ckreg_chk
  import ckreg_pkg::*;
#(
  parameter int unsigned NREG = 48,
  parameter int unsigned NSTG = 16,
  localparam int unsigned CW = $clog2(NSTG + 1)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 rx_valid_i,
  input logic [7:0]           rx_data_i,
  input logic                 ack_o,
  input logic                 we,
  input logic [7:0]           waddr,
  input logic                 commit,
  input logic                 rd_en,
  input logic [CW-1:0]        cnt,
  input logic [CW-1:0]        idx,
  input ck_state_e            st,
  input logic [NREG-1:0][7:0] regs
);
  AST_NO_STRAY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !($past(we) || $past(commit)) |-> $stable(regs)); // R7
  AST_COMMIT_ON_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |-> (rx_valid_i && ack_o)); // R6
  AST_BAD_CNT_NAK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_CNT && rx_valid_i && (rx_data_i == 8'd0 || rx_data_i > 8'(NSTG))) |-> !ack_o); // R5
  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_CDAT || st == ST_CRD) |-> (cnt >= CW'(1) && cnt <= CW'(NSTG) && idx <= cnt)); // R5
  AST_CSUM_NO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_CRD && idx == cnt) |-> !rd_en); // R9
  AST_PLAIN_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we |-> (waddr < 8'(NREG) && ack_o)); // R4
endmodule

bind ckreg_i2c_target ckreg_chk #(.NREG(NREG), .NSTG(NSTG)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .rx_valid_i(rx_valid_i), .rx_data_i(rx_data_i),
  .ack_o(ack_o), .we(we), .waddr(waddr), .commit(commit), .rd_en(rd_en),
  .cnt(cnt), .idx(idx), .st(st), .regs(regs)
);

// File: tb/test_ckreg_i2c_target.sv
module test_ckreg_i2c_target;
  localparam int CLK_PERIOD = 10;
  localparam int NREG = 48;

  logic clk_i = 0, rst_ni = 0;
  logic start_i = 0, stop_i = 0, addr_i = 0, rw_i = 0, rx_valid_i = 0, tx_req_i = 0;
  logic [7:0] rx_data_i = 0;
  logic ack_o;
  logic [7:0] tx_data_o;

  int errors = 0, checks = 0;
  logic [7:0] mdl [NREG];
  logic [7:0] dat [16];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ckreg_i2c_target i_ckreg_i2c_target (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ev_start();
    @(negedge clk_i); start_i = 1; @(posedge clk_i); #1 start_i = 0;
  endtask
  task automatic ev_stop();
    @(negedge clk_i); stop_i = 1; @(posedge clk_i); #1 stop_i = 0;
  endtask
  task automatic ev_addr(input bit rd);
    @(negedge clk_i); addr_i = 1; rw_i = rd; @(posedge clk_i); #1 addr_i = 0;
  endtask
  task automatic put(input logic [7:0] b, input bit exp, input string req);
    @(negedge clk_i); rx_valid_i = 1; rx_data_i = b; #1;
    chk(ack_o == exp, req, ack_o, exp);
    @(posedge clk_i); #1 rx_valid_i = 0;
  endtask
  task automatic get(input logic [7:0] exp, input string req);
    @(negedge clk_i); #1;
    chk(tx_data_o == exp, req, tx_data_o, exp);
    tx_req_i = 1; @(posedge clk_i); #1 tx_req_i = 0;
  endtask

  function automatic logic [7:0] mrd(input int a);
    return (a < NREG) ? mdl[a] : 8'hFF;
  endfunction

  task automatic plain_wr(input int a, input int n, input string req);
    ev_start(); ev_addr(0); put(8'(a), 1, req);
    for (int i = 0; i < n; i++) begin
      logic [7:0] v = 8'($urandom);
      put(v, (a + i) < NREG, (a + i) < NREG ? req : "R4");
      if (a + i < NREG) mdl[a + i] = v;
    end
    ev_stop();
  endtask

  task automatic plain_rd(input int a, input int n, input string req);
    ev_start(); ev_addr(0); put(8'(a), 1, req);
    ev_start(); ev_addr(1);
    for (int i = 0; i < n; i++) get(mrd(a + i), (a + i) < NREG ? req : "R4");
    ev_stop();
  endtask

  task automatic chk_wr(input int base, input int n, input bit bad);
    logic [7:0] s = 8'(n + base);
    ev_start(); ev_addr(0); put(8'h80, 1, "R5"); put(8'(n), 1, "R5"); put(8'(base), 1, "R10");
    for (int i = 0; i < n; i++) begin
      dat[i] = 8'($urandom);
      s = s + dat[i];
      put(dat[i], 1, "R6");
    end
    put(bad ? s ^ 8'h01 : s, !bad, bad ? "R7" : "R6");
    if (!bad) for (int i = 0; i < n; i++) mdl[base + i] = dat[i];
    put(8'h55, 0, "R11");
    ev_stop();
  endtask

  task automatic chk_rd(input int base, input int n);
    logic [7:0] s = 8'(n + base);
    ev_start(); ev_addr(0); put(8'h80, 1, "R5"); put(8'(n), 1, "R5"); put(8'(base), 1, "R10");
    ev_stop(); ev_start(); ev_addr(1);
    for (int i = 0; i < n; i++) begin
      get(mdl[base + i], "R9");
      s = s + mdl[base + i];
    end
    get(s, "R9");
    get(8'hFF, "R11");
    ev_stop();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2468));
    for (int i = 0; i < NREG; i++) mdl[i] = 8'h00;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;

    // R1: reset contents and pointer 0
    ev_start(); ev_addr(1);
    get(8'h00, "R1"); get(8'h00, "R1");
    ev_stop();
    plain_rd(20, 4, "R1");

    // R2 R3 directed then random plain traffic, R4 off the end
    plain_wr(0, 5, "R2");
    plain_rd(0, 5, "R3");
    plain_wr(45, 6, "R2");
    plain_rd(44, 7, "R3");
    plain_wr(60, 2, "R4");
    plain_rd(100, 2, "R4");
    // R3: pointer kept through stop and new read phase
    ev_start(); ev_addr(0); put(8'd10, 1, "R3"); ev_stop();
    ev_start(); ev_addr(1); get(mdl[10], "R3"); get(mdl[11], "R3"); ev_stop();
    ev_start(); ev_addr(1); get(mdl[12], "R3"); ev_stop();
    for (int k = 0; k < 15; k++) begin
      int a = $urandom_range(0, 47);
      int n = $urandom_range(1, 8);
      plain_wr(a, n, "R2");
      plain_rd(a, n, "R3");
    end

    // R6 R9: count edges 1 and 16 for sum fold on last byte
    chk_wr(0, 1, 0);  chk_rd(0, 1);
    chk_wr(32, 16, 0); chk_rd(32, 16);
    chk_wr(47, 1, 0); chk_rd(47, 1);
    // R7: corrupt sum leaves registers
    chk_wr(8, 6, 1);  chk_rd(8, 6);
    for (int k = 0; k < 20; k++) begin
      int n = $urandom_range(1, 16);
      int b = $urandom_range(0, NREG - n);
      chk_wr(b, n, ($urandom_range(0, 2) == 0));
      chk_rd(b, n);
    end

    // R5: bad counts NAKed and the rest dropped
    ev_start(); ev_addr(0); put(8'h80, 1, "R5"); put(8'd0, 0, "R5"); put(8'd3, 0, "R5"); ev_stop();
    ev_start(); ev_addr(0); put(8'h80, 1, "R5"); put(8'd17, 0, "R5"); put(8'd3, 0, "R5"); ev_stop();
    // R10: window past the end
    ev_start(); ev_addr(0); put(8'h80, 1, "R10"); put(8'd9, 1, "R10"); put(8'd40, 0, "R10");
    put(8'd1, 0, "R10"); ev_stop();
    chk_wr(40, 8, 0); chk_rd(40, 8);

    // R8: stop and restart mid checked write discard staging
    for (int m = 0; m < 2; m++) begin
      ev_start(); ev_addr(0); put(8'h80, 1, "R8"); put(8'd4, 1, "R8"); put(8'd2, 1, "R8");
      put(8'hA5, 1, "R8"); put(8'h5A, 1, "R8");
      if (m == 0) ev_stop(); else begin ev_start(); ev_addr(0); put(8'd30, 1, "R8"); end
      ev_stop();
      plain_rd(2, 4, "R8");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule